// File: doc/BRIEF.md
# Trace Resynchronization Interval Counter

This block sits inside an instruction-trace encoder. It decides when the encoder has to place a periodic synchronization packet into its output stream. A saturating resync counter advances only while tracing is on. The unit it counts is chosen at run time: emitted packets, hart clock cycles, or retired 16-bit instruction half-words summed over every retirement block. The counter is compared with a threshold that is captured while tracing is off.

When the counter reaches the threshold exactly, the block tells the encoder to send an ordinary branch/address packet. When the counter goes past the threshold, the block raises a sync request. This request stays up until the encoder reports that the sync packet went out. In packet mode the counter moves one step after each packet, so the sync request appears one message after the equality point. A fourth mode value turns the mechanism off.

Top module: `resync_interval`

## Requirements
- R1: With `modeSel` = 0 (off), the counter is forced to zero at every clock edge, any pending sync request is dropped, and both `forceAddr` and `syncReq` are low.
- R2: With `modeSel` = 1 (packet mode), the counter grows by one at each clock edge where `pktSent` is high while tracing is on. The new value is visible after that edge.
- R3: With `modeSel` = 2 (cycle mode), the counter grows by one at each clock edge while tracing is on.
- R4: With `modeSel` = 3 (half-word mode), the counter grows at each clock edge while tracing is on. The amount is the sum of all blocks' retired half-word counts in `retireHw`, where block b occupies bits [b*HW_W +: HW_W].
- R5: Tracing is on only when `onActive`, `onEnable`, `onRunning` and `onQualified` are all high. If any one of them is low, the counter does not change in any mode.
- R6: `forceAddr` is high whenever the mode is not off and the counter equals the captured threshold.
- R7: `syncReq` is high whenever the mode is not off and the counter exceeds the captured threshold. Once raised, it stays high until `syncSent` is seen, even if tracing stops or the counter is cleared.
- R8: A high `syncSent` at a clock edge clears the counter and the pending request. This takes priority over counting in that cycle.
- R9: In the first traced cycle after tracing was off, the counter is cleared and that cycle's activity is not counted.
- R10: The threshold input is captured only at edges where tracing is off. Changes made while tracing is on have no effect until tracing stops.
- R11: The counter saturates at its maximum value 2^CNT_W-1 and does not wrap.
- R12: Reset clears the counter, the pending request and the captured threshold. With mode off, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| onActive | input | 1 | Trace-on qualifier: encoder active |
| onEnable | input | 1 | Trace-on qualifier: encoder enabled |
| onRunning | input | 1 | Trace-on qualifier: tracing running |
| onQualified | input | 1 | Trace-on qualifier: current retirement qualifies |
| modeSel | input | 2 | 0 off, 1 packets, 2 cycles, 3 half-words |
| threshold | input | CNT_W | Resync threshold, captured while trace is off |
| retireHw | input | NUM_BLK*HW_W | Per-block retired half-word counts |
| pktSent | input | 1 | Strobe: one trace packet emitted |
| syncSent | input | 1 | Strobe: sync packet accepted by the packet generator |
| forceAddr | output | 1 | Counter equals threshold: send a branch/address packet |
| syncReq | output | 1 | Counter passed threshold: send a sync packet |

## Verification
The bench builds the block with CNT_W = 4, NUM_BLK = 2 and HW_W = 3. A 4-bit counter means a threshold of 15 reaches the saturation ceiling within a few cycles. Two 3-bit retirement lanes, each up to 7, can push the sum past that ceiling in a single step, so saturation and wrap-around differ clearly at the outputs. Because the threshold is small, the equal and greater-than points, and the sticky request across a trace restart, each appear within a handful of cycles in every mode.

// File: rtl/resync_pkg.sv
package resync_pkg;

  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_PKT = 2'd1,
    MODE_CYC = 2'd2,
    MODE_HW  = 2'd3
  } syncMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;    // zero the counter
    logic advance;  // tracing is on: add this cycle's step
    logic ldThr;    // capture threshold input
  } dpCtl_t;

endpackage

// File: rtl/resync_dp.sv
module resync_dp
  import resync_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_BLK = 2,
  parameter int HW_W    = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpCtl_t                  ctl,
  input  syncMode_e               mode,
  input  logic [NUM_BLK*HW_W-1:0] retireHw,
  input  logic                    pktSent,
  input  logic [CNT_W-1:0]        threshold,
  output logic                    cntEq,
  output logic                    cntGt
);

  localparam int SUM_W = HW_W + $clog2(NUM_BLK + 1);
  localparam int EXT_W = ((CNT_W > SUM_W) ? CNT_W : SUM_W) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt, thrReg, nextCnt;
  logic [SUM_W-1:0] laneSum [NUM_BLK+1];
  logic [EXT_W-1:0] stepAmt, extSum;

  // running sum across retirement lanes
  assign laneSum[0] = '0;
  for (genvar b = 0; b < NUM_BLK; b++) begin : g_lane
    assign laneSum[b+1] = laneSum[b] + SUM_W'(retireHw[b*HW_W +: HW_W]);
  end

  always_comb begin
    unique case (mode)
      MODE_PKT: stepAmt = EXT_W'(pktSent);
      MODE_CYC: stepAmt = EXT_W'(1);
      MODE_HW:  stepAmt = EXT_W'(laneSum[NUM_BLK]);
      default:  stepAmt = '0;
    endcase
    extSum  = EXT_W'(cnt) + stepAmt;
    nextCnt = (extSum > EXT_W'(CNT_MAX)) ? CNT_MAX : extSum[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      thrReg <= '0;
    end else begin
      if (ctl.clear)        cnt <= '0;
      else if (ctl.advance) cnt <= nextCnt;
      if (ctl.ldThr)        thrReg <= threshold;
    end
  end

  assign cntEq = (cnt == thrReg);
  assign cntGt = (cnt > thrReg);

  // R11
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && !ctl.clear && cnt == CNT_MAX) |=> cnt == CNT_MAX);

  // R5
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.advance && !ctl.clear) |=> $stable(cnt));

  // R10
  thr_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.ldThr |=> $stable(thrReg));

  // R1
  off_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_OFF) |=> cnt == '0);

endmodule

// File: rtl/resync_ctrl.sv
module resync_ctrl
  import resync_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      onActive,
  input  logic      onEnable,
  input  logic      onRunning,
  input  logic      onQualified,
  input  syncMode_e mode,
  input  logic      syncSent,
  input  logic      cntEq,
  input  logic      cntGt,
  output dpCtl_t    ctl,
  output logic      forceAddr,
  output logic      syncReq
);

  logic traceOn, traceOnQ, traceStart, modeOff, syncPend;

  assign traceOn    = onActive & onEnable & onRunning & onQualified;
  assign traceStart = traceOn & ~traceOnQ;
  assign modeOff    = (mode == MODE_OFF);

  assign ctl.clear   = modeOff | syncSent | traceStart;
  assign ctl.advance = traceOn;
  assign ctl.ldThr   = ~traceOn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      traceOnQ <= 1'b0;
      syncPend <= 1'b0;
    end else begin
      traceOnQ <= traceOn;
      if (modeOff || syncSent) syncPend <= 1'b0;
      else if (cntGt)          syncPend <= 1'b1;
    end
  end

  assign forceAddr = ~modeOff & cntEq;
  assign syncReq   = ~modeOff & (syncPend | cntGt);

  // R7
  req_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (syncReq && !syncSent) |=> (syncReq || mode == MODE_OFF));

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncSent |=> !syncReq);

endmodule

// File: rtl/resync_interval.sv
module resync_interval
  import resync_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_BLK = 2,
  parameter int HW_W    = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    onActive,
  input  logic                    onEnable,
  input  logic                    onRunning,
  input  logic                    onQualified,
  input  logic [1:0]              modeSel,
  input  logic [CNT_W-1:0]        threshold,
  input  logic [NUM_BLK*HW_W-1:0] retireHw,
  input  logic                    pktSent,
  input  logic                    syncSent,
  output logic                    forceAddr,
  output logic                    syncReq
);

  syncMode_e modeE;
  dpCtl_t    ctl;
  logic      cntEq, cntGt;

  assign modeE = syncMode_e'(modeSel);

  resync_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .onActive(onActive), .onEnable(onEnable),
    .onRunning(onRunning), .onQualified(onQualified),
    .mode(modeE), .syncSent(syncSent),
    .cntEq(cntEq), .cntGt(cntGt),
    .ctl(ctl), .forceAddr(forceAddr), .syncReq(syncReq)
  );

  resync_dp #(.CNT_W(CNT_W), .NUM_BLK(NUM_BLK), .HW_W(HW_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .mode(modeE),
    .retireHw(retireHw), .pktSent(pktSent), .threshold(threshold),
    .cntEq(cntEq), .cntGt(cntGt)
  );

endmodule

// File: tb/resync_interval_tb.sv
module resync_interval_tb;

  localparam int CNT_W = 4;
  localparam int NUM_BLK = 2;
  localparam int HW_W = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic onActive = 0, onEnable = 0, onRunning = 0, onQualified = 0;
  logic [1:0] modeSel = 2'd0;
  logic [CNT_W-1:0] threshold = '0;
  logic [NUM_BLK*HW_W-1:0] retireHw = '0;
  logic pktSent = 0, syncSent = 0;
  logic forceAddr, syncReq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  resync_interval #(.CNT_W(CNT_W), .NUM_BLK(NUM_BLK), .HW_W(HW_W)) u_dut (
    .clk(clk), .rstN(rstN),
    .onActive(onActive), .onEnable(onEnable),
    .onRunning(onRunning), .onQualified(onQualified),
    .modeSel(modeSel), .threshold(threshold), .retireHw(retireHw),
    .pktSent(pktSent), .syncSent(syncSent),
    .forceAddr(forceAddr), .syncReq(syncReq)
  );

  // fields: mode[12:11] on[10] pkt[9] hw0[8:6] hw1[5:3] sync[2] expF[1] expS[0]
  // threshold held at 3 throughout the table
  localparam logic [12:0] VEC [0:32] = '{
    {2'd1,1'b1,1'b1,3'd0,3'd0,1'b0,1'b0,1'b0}, // R9 start clears
    {2'd1,1'b1,1'b1,3'd0,3'd0,1'b0,1'b0,1'b0}, // R2 cnt1
    {2'd1,1'b1,1'b0,3'd0,3'd0,1'b0,1'b0,1'b0}, // R2 no pkt, cnt1
    {2'd1,1'b1,1'b1,3'd0,3'd0,1'b0,1'b0,1'b0}, // R2 cnt2
    {2'd1,1'b1,1'b1,3'd0,3'd0,1'b0,1'b1,1'b0}, // R6 cnt3
    {2'd1,1'b1,1'b1,3'd0,3'd0,1'b0,1'b0,1'b1}, // R7 cnt4
    {2'd1,1'b1,1'b0,3'd0,3'd0,1'b0,1'b0,1'b1}, // R7 held
    {2'd1,1'b1,1'b0,3'd0,3'd0,1'b1,1'b0,1'b0}, // R8 ack
    {2'd1,1'b0,1'b1,3'd0,3'd0,1'b0,1'b0,1'b0}, // R5 off
    {2'd2,1'b1,1'b0,3'd0,3'd0,1'b0,1'b0,1'b0}, // R9 start
    {2'd2,1'b1,1'b0,3'd0,3'd0,1'b0,1'b0,1'b0}, // R3 cnt1
    {2'd2,1'b1,1'b0,3'd0,3'd0,1'b0,1'b0,1'b0}, // R3 cnt2
    {2'd2,1'b0,1'b0,3'd0,3'd0,1'b0,1'b0,1'b0}, // R5 off cnt2
    {2'd2,1'b1,1'b0,3'd0,3'd0,1'b0,1'b0,1'b0}, // R9 restart cnt0
    {2'd2,1'b1,1'b0,3'd0,3'd0,1'b0,1'b0,1'b0}, // R3 cnt1
    {2'd2,1'b1,1'b0,3'd0,3'd0,1'b0,1'b0,1'b0}, // R3 cnt2
    {2'd2,1'b1,1'b0,3'd0,3'd0,1'b0,1'b1,1'b0}, // R3 cnt3
    {2'd2,1'b1,1'b0,3'd0,3'd0,1'b0,1'b0,1'b1}, // R3 cnt4
    {2'd2,1'b1,1'b0,3'd0,3'd0,1'b1,1'b0,1'b0}, // R8 ack beats count
    {2'd3,1'b1,1'b0,3'd1,3'd1,1'b0,1'b0,1'b0}, // R4 cnt2
    {2'd3,1'b1,1'b0,3'd0,3'd1,1'b0,1'b1,1'b0}, // R4 cnt3
    {2'd3,1'b1,1'b0,3'd2,3'd0,1'b0,1'b0,1'b1}, // R4 cnt5
    {2'd3,1'b1,1'b0,3'd0,3'd0,1'b1,1'b0,1'b0}, // R8 ack
    {2'd3,1'b1,1'b0,3'd7,3'd7,1'b0,1'b0,1'b1}, // R4 cnt14
    {2'd0,1'b1,1'b0,3'd7,3'd7,1'b0,1'b0,1'b0}, // R1 off mode
    {2'd0,1'b1,1'b0,3'd7,3'd7,1'b0,1'b0,1'b0}, // R1 off mode
    {2'd3,1'b1,1'b0,3'd1,3'd2,1'b0,1'b1,1'b0}, // R1 resumed from 0, cnt3
    {2'd3,1'b0,1'b0,3'd7,3'd7,1'b0,1'b1,1'b0}, // R5 off, holds 3
    {2'd3,1'b0,1'b0,3'd0,3'd0,1'b0,1'b1,1'b0}, // R5 off, holds 3
    {2'd3,1'b1,1'b0,3'd0,3'd0,1'b0,1'b0,1'b0}, // R9 restart
    {2'd3,1'b1,1'b0,3'd1,3'd1,1'b0,1'b0,1'b0}, // R4 cnt2
    {2'd3,1'b1,1'b0,3'd1,3'd0,1'b0,1'b1,1'b0}, // R4 cnt3
    {2'd3,1'b1,1'b0,3'd0,3'd0,1'b1,1'b0,1'b0}  // R8 ack
  };

  task automatic setOn(input logic v);
    onActive = v; onEnable = v; onRunning = v; onQualified = v;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
    end
  endtask

  task automatic chkBoth(input string req, input logic expF, input logic expS);
    chk(req, forceAddr, expF, "forceAddr");
    chk(req, syncReq, expS, "syncReq");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R12 reset
    repeat (3) step();
    chkBoth("R12", 1'b0, 1'b0);
    rstN = 1'b1;
    threshold = 4'd3;
    step();
    step();
    chkBoth("R12", 1'b0, 1'b0);

    // vector table, threshold 3
    for (int i = 0; i < 33; i++) begin
      modeSel = VEC[i][12:11];
      setOn(VEC[i][10]);
      pktSent = VEC[i][9];
      retireHw = {VEC[i][5:3], VEC[i][8:6]};
      syncSent = VEC[i][2];
      step();
      chk($sformatf("vec%0d", i), forceAddr, VEC[i][1], "forceAddr");
      chk($sformatf("vec%0d", i), syncReq, VEC[i][0], "syncReq");
    end
    pktSent = 0; syncSent = 0; retireHw = '0;

    // R10: threshold changed while tracing has no effect
    modeSel = 2'd2;
    threshold = 4'd1;
    step(); // cnt1
    step(); // cnt2
    chkBoth("R10", 1'b0, 1'b0);
    step(); // cnt3
    chkBoth("R10", 1'b1, 1'b0);
    setOn(1'b0);
    step(); // threshold 1 captured, cnt3 > 1
    chkBoth("R10", 1'b0, 1'b1);
    syncSent = 1; step(); syncSent = 0;
    chkBoth("R8", 1'b0, 1'b0);

    // R11: saturation at 15
    threshold = 4'd15;
    step();
    modeSel = 2'd3;
    retireHw = {3'd7, 3'd7};
    setOn(1'b1);
    step(); // start
    step(); // 14
    chkBoth("R11", 1'b0, 1'b0);
    step(); // 28 -> 15
    chkBoth("R11", 1'b1, 1'b0);
    step();
    chkBoth("R11", 1'b1, 1'b0);
    step();
    chkBoth("R11", 1'b1, 1'b0);
    retireHw = '0;
    syncSent = 1; step(); syncSent = 0;

    // R7: request survives trace stop and restart
    setOn(1'b0);
    threshold = 4'd2;
    modeSel = 2'd2;
    step();
    setOn(1'b1);
    step(); step(); step(); // 0,1,2
    chkBoth("R6", 1'b1, 1'b0);
    step(); // 3
    chkBoth("R7", 1'b0, 1'b1);
    setOn(1'b0);
    step();
    chkBoth("R7", 1'b0, 1'b1);
    setOn(1'b1);
    step(); // restart clears counter
    chkBoth("R7", 1'b0, 1'b1);
    step(); // cnt1
    chkBoth("R7", 1'b0, 1'b1);
    syncSent = 1; step(); syncSent = 0;
    chkBoth("R8", 1'b0, 1'b0);

    // R5: each qualifier alone blocks counting (cycle mode, threshold 1)
    threshold = 4'd1;
    for (int q = 0; q < 4; q++) begin
      setOn(1'b0);
      syncSent = 1; step(); syncSent = 0;
      setOn(1'b1);
      step(); // start
      step(); // cnt1
      case (q)
        0: onActive = 0;
        1: onEnable = 0;
        2: onRunning = 0;
        default: onQualified = 0;
      endcase
      step(); step();
      chkBoth($sformatf("R5 q%0d", q), 1'b1, 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule